// File: doc/BRIEF.md
# Indexed Configuration RAM with Self-Filling Checksum

This block holds a 64-byte battery-style configuration memory reached through two host ports: an index port and a data port. The host writes a register number to the index port, then reads or writes the chosen byte through the data port. The index register is 7 bits wide. Only its low 6 bits select a byte, so the upper half of the index range reads and writes the same 64 bytes as the lower half. The reset contents come from a parameter image.

A sequencer computes a 16-bit additive checksum over bytes 0x10 to 0x2C and stores it in two reserved bytes, high byte at 0x2E and low byte at 0x2F. It runs exactly once, on the first data-port access after reset. That access is held pending while the sequencer runs, and `ready` is low for that time. The pending access completes after both checksum bytes are stored, so a triggering write to a checksum slot replaces the computed value. Index-port accesses never start the sequencer.

Host FSM (`host_state_t`): HOST_IDLE → HOST_WAIT_SUM on a data access before the checksum exists; HOST_WAIT_SUM → HOST_APPLY on the sequencer's final store; HOST_APPLY → HOST_IDLE after the pending access is performed. Checksum FSM (`seq_state_t`): SQ_IDLE → SQ_ADD on start; SQ_ADD stays while summing and goes to SQ_PUT_HI after byte 0x2C; SQ_PUT_HI → SQ_PUT_LO → SQ_SPENT; SQ_SPENT is terminal until reset.

Top module: `idx_cfg_ram`

## Requirements
- R1: After reset the index reads 0x00, `ready` is 1, `rvalid` is 0. Bytes 0x0A=0x26, 0x0B=0x02, 0x0D=0x80 and 0x32=0x19. Byte i for 0x10 ≤ i ≤ 0x2C is (i*29+7) mod 256. Every other byte is 0x00.
- R2: An index write (`sel_data`=0, `wr_stb`) stores `wdata` & 0x7F. An index read returns {0, index} on `rdata`.
- R3: Data accesses use only index bits [5:0], so index i and index i+0x40 reach the same byte.
- R4: The checksum is the 16-bit sum of bytes 0x10..0x2C. Its high byte is stored at 0x2E and its low byte at 0x2F.
- R5: The first data access after reset starts the checksum. `ready` is low from the next cycle for exactly 32 cycles: 29 sum cycles, 2 store cycles and 1 apply cycle.
- R6: Later data accesses never restart the checksum. `ready` stays high, and 0x2E/0x2F keep the sum of the contents at trigger time.
- R7: A triggering write is applied after the checksum is stored. It lands at its byte, and a write to 0x2E or 0x2F overrides the checksum byte.
- R8: A triggering read returns the byte, including any checksum value, with `rvalid`=1 in the cycle `ready` rises.
- R9: With `ready` high, a read strobe gives `rdata` and a one-cycle `rvalid` after the next clock edge. A data write is visible to the next read.
- R10: Index-port accesses leave `ready` high and do not start the checksum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_data | input | 1 | 0 selects the index port, 1 selects the data port |
| rd_stb | input | 1 | One-cycle read strobe |
| wr_stb | input | 1 | One-cycle write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| rvalid | output | 1 | One-cycle pulse marking new read data |
| ready | output | 1 | Low while a triggering access waits on the checksum |

## Verification
The bench runs three reset scenarios, each starting the checksum differently: a read through an aliased index, a write into a checksum slot, and a write into the summed window. These show whether the sum is taken before or after the triggering write, and whether the write overrides the stored sum. The stall length is counted in each case. A second access checks that nothing is recomputed. A sweep over all 128 index values, writing and reading back through the opposite alias, separates 6-bit from 7-bit addressing. A full 64-byte readback compares the reset image and the computed checksum against values the bench derives arithmetically.

// File: rtl/idx_cfg_pkg.sv
package idx_cfg_pkg;

    localparam int IMG_DEPTH = 64;
    localparam int IMG_DW    = 8;

    typedef enum logic [1:0] {
        HOST_IDLE,
        HOST_WAIT_SUM,
        HOST_APPLY
    } host_state_t;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_ADD,
        SQ_PUT_HI,
        SQ_PUT_LO,
        SQ_SPENT
    } seq_state_t;

    function automatic logic [IMG_DEPTH*IMG_DW-1:0] default_image();
        logic [IMG_DEPTH*IMG_DW-1:0] img;
        img = '0;
        for (int i = 16; i <= 44; i++) begin
            img[i*IMG_DW +: IMG_DW] = IMG_DW'((i * 29 + 7) % 256);
        end
        img[8'h0A*IMG_DW +: IMG_DW] = 8'h26;
        img[8'h0B*IMG_DW +: IMG_DW] = 8'h02;
        img[8'h0D*IMG_DW +: IMG_DW] = 8'h80;
        img[8'h32*IMG_DW +: IMG_DW] = 8'h19;
        return img;
    endfunction

endpackage

// File: rtl/cfg_byte_store.sv
module cfg_byte_store #(
    parameter int DW = 8,
    parameter int AW = 6,
    parameter logic [(1<<AW)*DW-1:0] INIT = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [DW-1:0] rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_b
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= INIT[i*DW +: DW];
            end
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata_a = mem_q[raddr_a];
    assign rdata_b = mem_q[raddr_b];

endmodule

// File: rtl/cfg_sum_seq.sv
module cfg_sum_seq
    import idx_cfg_pkg::*;
#(
    parameter int DW     = 8,
    parameter int AW     = 6,
    parameter int WIN_LO = 16,
    parameter int WIN_HI = 44,
    parameter int DST_HI = 46,
    parameter int DST_LO = 47
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] rd_byte,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [DW-1:0] wdata,
    output logic          busy,
    output logic          last,
    output logic          spent
);
    localparam int SW = 2 * DW;
    localparam logic [AW-1:0] LO_A = AW'(WIN_LO);
    localparam logic [AW-1:0] HI_A = AW'(WIN_HI);

    seq_state_t    sq_q, sq_d;
    logic [AW-1:0] ptr_q;
    logic [SW-1:0] acc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sq_q <= SQ_IDLE;
        else        sq_q <= sq_d;
    end

    always_comb begin
        sq_d = sq_q;
        unique case (sq_q)
            SQ_IDLE:   if (start) sq_d = SQ_ADD;
            SQ_ADD:    if (ptr_q == HI_A) sq_d = SQ_PUT_HI;
            SQ_PUT_HI: sq_d = SQ_PUT_LO;
            SQ_PUT_LO: sq_d = SQ_SPENT;
            SQ_SPENT:  sq_d = SQ_SPENT;
            default:   sq_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
            acc_q <= '0;
        end else if (sq_q == SQ_IDLE && start) begin
            ptr_q <= LO_A;
            acc_q <= '0;
        end else if (sq_q == SQ_ADD) begin
            ptr_q <= ptr_q + 1'b1;
            acc_q <= acc_q + {{DW{1'b0}}, rd_byte};
        end
    end

    always_comb begin
        rd_addr = ptr_q;
        we      = (sq_q == SQ_PUT_HI) || (sq_q == SQ_PUT_LO);
        waddr   = (sq_q == SQ_PUT_HI) ? AW'(DST_HI) : AW'(DST_LO);
        wdata   = (sq_q == SQ_PUT_HI) ? acc_q[SW-1:DW] : acc_q[DW-1:0];
        busy    = (sq_q == SQ_ADD) || we;
        last    = (sq_q == SQ_PUT_LO);
        spent   = (sq_q == SQ_SPENT);
    end

    // R4
    ptr_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_q == SQ_ADD) |-> (ptr_q >= LO_A && ptr_q <= HI_A));

    // R4
    hi_then_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_q == SQ_PUT_HI) |=> (sq_q == SQ_PUT_LO));

    // R6
    spent_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_q == SQ_SPENT) |=> (sq_q == SQ_SPENT));

endmodule

// File: rtl/idx_cfg_ram.sv
module idx_cfg_ram
    import idx_cfg_pkg::*;
#(
    parameter int DW     = 8,
    parameter int IW     = 7,
    parameter int AW     = 6,
    parameter int WIN_LO = 16,
    parameter int WIN_HI = 44,
    parameter int DST_HI = 46,
    parameter int DST_LO = 47,
    parameter logic [(1<<AW)*DW-1:0] INIT = idx_cfg_pkg::default_image()
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_data,
    input  logic          rd_stb,
    input  logic          wr_stb,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          rvalid,
    output logic          ready
);
    localparam int PADW = DW - IW;

    host_state_t   hs_q, hs_d;
    logic [IW-1:0] idx_q;
    logic [AW-1:0] pend_addr_q;
    logic          pend_we_q;
    logic [DW-1:0] pend_wdata_q;
    logic [DW-1:0] rdata_q;
    logic          rvalid_q;

    logic          data_acc, seq_start, host_we, host_rd, idx_rd;
    logic [AW-1:0] host_addr;
    logic [DW-1:0] host_wdata, host_byte;

    logic          seq_we, seq_busy, seq_last, seq_spent;
    logic [AW-1:0] seq_raddr, seq_waddr;
    logic [DW-1:0] seq_wdata, seq_byte;

    logic          st_we;
    logic [AW-1:0] st_waddr;
    logic [DW-1:0] st_wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hs_q <= HOST_IDLE;
        else        hs_q <= hs_d;
    end

    always_comb begin
        data_acc   = sel_data && (rd_stb || wr_stb);
        seq_start  = 1'b0;
        host_we    = 1'b0;
        host_rd    = 1'b0;
        idx_rd     = 1'b0;
        host_addr  = idx_q[AW-1:0];
        host_wdata = wdata;
        hs_d       = hs_q;
        unique case (hs_q)
            HOST_IDLE: begin
                idx_rd = !sel_data && rd_stb && !wr_stb;
                if (data_acc && !seq_spent) begin
                    seq_start = 1'b1;
                    hs_d      = HOST_WAIT_SUM;
                end else if (data_acc) begin
                    host_we = wr_stb;
                    host_rd = !wr_stb;
                end
            end
            HOST_WAIT_SUM: if (seq_last) hs_d = HOST_APPLY;
            HOST_APPLY: begin
                host_addr  = pend_addr_q;
                host_wdata = pend_wdata_q;
                host_we    = pend_we_q;
                host_rd    = !pend_we_q;
                hs_d       = HOST_IDLE;
            end
            default: hs_d = HOST_IDLE;
        endcase
        ready = (hs_q == HOST_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q        <= '0;
            pend_addr_q  <= '0;
            pend_we_q    <= 1'b0;
            pend_wdata_q <= '0;
            rdata_q      <= '0;
            rvalid_q     <= 1'b0;
        end else begin
            rvalid_q <= host_rd || idx_rd;
            if (hs_q == HOST_IDLE && !sel_data && wr_stb) idx_q <= wdata[IW-1:0];
            if (seq_start) begin
                pend_addr_q  <= idx_q[AW-1:0];
                pend_we_q    <= wr_stb;
                pend_wdata_q <= wdata;
            end
            if (host_rd)     rdata_q <= host_byte;
            else if (idx_rd) rdata_q <= {{PADW{1'b0}}, idx_q};
        end
    end

    assign rdata  = rdata_q;
    assign rvalid = rvalid_q;

    assign st_we    = seq_we || host_we;
    assign st_waddr = seq_we ? seq_waddr : host_addr;
    assign st_wdata = seq_we ? seq_wdata : host_wdata;

    cfg_byte_store #(.DW(DW), .AW(AW), .INIT(INIT)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (st_we),
        .waddr   (st_waddr),
        .wdata   (st_wdata),
        .raddr_a (host_addr),
        .rdata_a (host_byte),
        .raddr_b (seq_raddr),
        .rdata_b (seq_byte)
    );

    cfg_sum_seq #(
        .DW(DW), .AW(AW), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI),
        .DST_HI(DST_HI), .DST_LO(DST_LO)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (seq_start),
        .rd_addr (seq_raddr),
        .rd_byte (seq_byte),
        .we      (seq_we),
        .waddr   (seq_waddr),
        .wdata   (seq_wdata),
        .busy    (seq_busy),
        .last    (seq_last),
        .spent   (seq_spent)
    );

    // R5
    busy_hides_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_busy |-> !ready);

    // R7
    one_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(seq_we && host_we));

    // R8
    apply_after_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_q == HOST_APPLY) |-> seq_spent);

    // R10
    index_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !sel_data) |=> ready);

endmodule

// File: tb/tb_idx_cfg_ram.sv
module tb_idx_cfg_ram;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       sel_data, rd_stb, wr_stb;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic       rvalid, ready;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;
    logic [7:0] img [64];

    always #10 clk = ~clk;

    idx_cfg_ram dut (
        .clk(clk), .rst_n(rst_n), .sel_data(sel_data), .rd_stb(rd_stb),
        .wr_stb(wr_stb), .wdata(wdata), .rdata(rdata), .rvalid(rvalid),
        .ready(ready)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 64; i++) img[i] = (i >= 16 && i <= 44) ? 8'((i * 29 + 7) % 256) : 8'h00;
        img[8'h0A] = 8'h26; img[8'h0B] = 8'h02; img[8'h0D] = 8'h80; img[8'h32] = 8'h19;
    endtask

    function automatic logic [15:0] model_sum();
        logic [15:0] s = 16'h0;
        for (int i = 16; i <= 44; i++) s = s + {8'h0, img[i]};
        return s;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; sel_data = 1'b0; rd_stb = 1'b0; wr_stb = 1'b0; wdata = 8'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        model_reset();
    endtask

    task automatic access(input bit sel, input bit wr, input logic [7:0] v,
                          output logic [7:0] rd, output int low, output bit rv);
        sel_data = sel; wr_stb = wr; rd_stb = !wr; wdata = v;
        @(posedge clk);
        @(negedge clk);
        wr_stb = 1'b0; rd_stb = 1'b0;
        low = 0;
        while (!ready) begin
            low++;
            @(negedge clk);
        end
        rd = rdata; rv = rvalid;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0]  rd;
        int          low;
        bit          rv;
        logic [15:0] s;

        // Scenario A: read trigger through aliased index
        do_reset();
        check(ready === 1'b1, "R1 ready", ready, 1);
        check(rvalid === 1'b0, "R1 rvalid", rvalid, 0);
        access(0, 0, 8'h00, rd, low, rv);
        check(rd === 8'h00 && rv, "R1 index", rd, 0);
        access(0, 1, 8'hCA, rd, low, rv);
        check(low == 0, "R10 index write stall", low, 0);
        access(0, 0, 8'h00, rd, low, rv);
        check(rd === 8'h4A && rv, "R2 index mask", rd, 8'h4A);
        check(low == 0, "R10 index read stall", low, 0);
        s = model_sum();
        access(1, 0, 8'h00, rd, low, rv);
        check(low == 32, "R5 stall length", low, 32);
        check(rd === 8'h26 && rv, "R8 R3 trigger read", rd, 8'h26);
        img[46] = s[15:8]; img[47] = s[7:0];
        for (int i = 0; i < 64; i++) begin
            access(0, 1, 8'(i), rd, low, rv);
            access(1, 0, 8'h00, rd, low, rv);
            check(rd === img[i] && rv && low == 0, "R1 R4 R9 image", rd, img[i]);
        end
        // R3 R9: write all 128 index values, read back through opposite alias
        for (int i = 0; i < 128; i++) begin
            access(0, 1, 8'(i), rd, low, rv);
            access(1, 1, 8'((i * 7 + 3) % 256), rd, low, rv);
            check(low == 0, "R6 no restall", low, 0);
            img[i % 64] = 8'((i * 7 + 3) % 256);
        end
        for (int i = 0; i < 64; i++) begin
            access(0, 1, 8'(i ^ 8'h40), rd, low, rv);
            access(1, 0, 8'h00, rd, low, rv);
            check(rd === img[i] && rv, "R3 alias", rd, img[i]);
        end

        // Scenario B: trigger write into high checksum slot
        do_reset();
        s = model_sum();
        access(0, 1, 8'h2E, rd, low, rv);
        access(1, 1, 8'hAB, rd, low, rv);
        check(low == 32, "R5 write stall", low, 32);
        access(1, 0, 8'h00, rd, low, rv);
        check(rd === 8'hAB, "R7 override 2E", rd, 8'hAB);
        access(0, 1, 8'h2F, rd, low, rv);
        access(1, 0, 8'h00, rd, low, rv);
        check(rd === s[7:0], "R4 low byte", rd, s[7:0]);

        // Scenario C: trigger write into summed window
        do_reset();
        s = model_sum();
        access(0, 1, 8'h20, rd, low, rv);
        access(1, 1, 8'h55, rd, low, rv);
        check(low == 32, "R5 window stall", low, 32);
        access(1, 0, 8'h00, rd, low, rv);
        check(rd === 8'h55 && low == 0, "R7 write applied", rd, 8'h55);
        access(0, 1, 8'h6E, rd, low, rv);
        access(1, 0, 8'h00, rd, low, rv);
        check(rd === s[15:8], "R6 R4 sum hi before write", rd, s[15:8]);
        access(0, 1, 8'h2F, rd, low, rv);
        access(1, 0, 8'h00, rd, low, rv);
        check(rd === s[7:0] && low == 0, "R6 sum lo kept", rd, s[7:0]);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule